// File: doc/BRIEF.md
# Endpoint Buffer Handshake Flag Logic

This block tracks the fill state of one endpoint's data buffer, which a CPU-side byte port and a USB-side byte port share. In the transmit direction the CPU fills the buffer and the USB side drains it. In the receive direction the USB side fills the buffer and the CPU drains it. Each side counts its own bytes against a programmable length. When a side completes, ownership of the buffer passes to the other side. Two request flags report these events in a small interrupt register: a start-of-data flag for completions on the USB side and an end-of-data flag for completions on the CPU side. Reading the register clears both flags.

In ping-pong mode the buffer has two pages. The CPU owns one page and the USB side owns the other. The pages swap only when both sides have finished, and a swap raises both flags in the same cycle. Endpoint 0 has extra rules. A finished status-in stage sets the start-of-data flag and the next SETUP token clears it. Byte strobes that arrive during a status phase are never counted.

The block refuses CPU accesses that the current buffer state does not allow. It reports each refused access as a one-cycle error pulse.

Top module: `ep_buf_flags`

## Requirements
- R1: Single-buffer transmit (`cfg_dir_in`=1, `cfg_dual`=0). Each accepted `cpu_wr` increments `cpu_cnt` by one. The write that brings the count to `cfg_max_len` has these effects at the following clock edge: `flags_q[1]` (end of data) goes to 1, `cpu_cnt` returns to 0 and `cpu_wr_ok` drops to 0.
- R2: Single-buffer receive (`cfg_dir_in`=0). Each accepted `cpu_rd` increments `cpu_cnt`. The read that brings the count to `cfg_usb_len` sets `flags_q[1]` and drops `cpu_rd_ok` to 0.
- R3: Single-buffer transmit. Each `usb_rd` counts in `usb_cnt` while the USB side owns the buffer. The strobe that brings the count to `cfg_usb_len` sets `flags_q[0]` (start of data), zeroes both counters and raises `cpu_wr_ok` again.
- R4: Single-buffer receive. Each `usb_wr` counts in `usb_cnt` while the USB side owns the buffer. The strobe that reaches `cfg_usb_len` sets `flags_q[0]` and raises `cpu_rd_ok`.
- R5: A cycle with `flags_rd`=1 clears every flag at the next edge, unless that flag is being set in the same cycle.
- R6: When a flag-setting event and `flags_rd` fall in the same cycle, that flag reads 1 after the edge.
- R7: A CPU strobe whose matching `*_ok` is 0 leaves `cpu_cnt` unchanged. It produces `cpu_err`=1 for exactly the following cycle. A cycle with no refused strobe is followed by `cpu_err`=0.
- R8: Ping-pong mode (`cfg_dual`=1). A side that has finished is blocked until the swap. The swap happens when the CPU count has reached its length and the USB count has reached `cfg_usb_len`, either earlier or in this cycle. At the swap both flag bits are set together, `cpu_page` toggles and both counters clear. The USB page starts empty in transmit, and the CPU page starts empty in receive.
- R9: While `usb_status_phase`=1, USB byte strobes do not change `usb_cnt` and never set `flags_q[0]`.
- R10: With `cfg_ep0`=1, `usb_status_in_done` sets `flags_q[0]` and `usb_setup` clears it. If both arrive in the same cycle, the flag is set.
- R11: After reset the flags and counters are 0. During the first cycle after reset both CPU access permissions are 0. From the next cycle, the permission for the CPU's own direction follows the initial ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_in | input | 1 | 1 = transmit (CPU writes, USB reads), 0 = receive |
| cfg_dual | input | 1 | Ping-pong two-page mode |
| cfg_ep0 | input | 1 | Apply endpoint-0 status rules |
| cfg_max_len | input | 10 | CPU write count that fills the buffer in transmit |
| cfg_usb_len | input | 10 | USB packet byte count, also the CPU read count in receive |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_rd | input | 1 | CPU byte read strobe |
| usb_wr | input | 1 | USB-side byte write strobe (receive) |
| usb_rd | input | 1 | USB-side byte read strobe (transmit) |
| usb_setup | input | 1 | SETUP token seen |
| usb_status_phase | input | 1 | Control status phase in progress |
| usb_status_in_done | input | 1 | Status-in stage completed |
| flags_rd | input | 1 | Read strobe of the flag register |
| flags_q | output | 2 | Bit 0 start of data, bit 1 end of data |
| cpu_cnt | output | 10 | CPU-side byte count |
| usb_cnt | output | 10 | USB-side byte count |
| cpu_wr_ok | output | 1 | CPU write currently permitted |
| cpu_rd_ok | output | 1 | CPU read currently permitted |
| cpu_err | output | 1 | Pulse after a refused CPU access |
| cpu_page | output | 1 | Page index currently owned by the CPU |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a flag being set and a read of the flag register clearing it. The second pair, in ping-pong mode, is the last CPU byte and the last USB byte arriving together, so that both flags rise at once. The bench forces the first pair directly by issuing a read on the cycle of the completing byte. Random traffic then produces both pairs many times across all four direction and mode combinations. A bench model derived from the requirements predicts each outcome, and every cycle is judged by comparing the flags, counters, page and permissions with that model.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;

    typedef enum logic [1:0] {
        ST_INIT     = 2'd0,
        ST_CPU_OWN  = 2'd1,
        ST_USB_OWN  = 2'd2,
        ST_PINGPONG = 2'd3
    } own_state_e;

    localparam int FLAG_W   = 2;
    localparam int FLAG_SOD = 0;
    localparam int FLAG_EOD = 1;
    localparam int SIDE_N   = 2;
    localparam int SIDE_CPU = 0;
    localparam int SIDE_USB = 1;

endpackage

// File: rtl/ep_side_counter.sv
module ep_side_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;
    assign hit     = inc && (cnt_inc == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt_inc;
        end
    end
endmodule

// File: rtl/ep_own_fsm.sv
module ep_own_fsm
    import ep_buf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_dir_in,
    input  logic cfg_dual,
    input  logic cpu_wr,
    input  logic cpu_rd,
    input  logic usb_xfer,
    input  logic usb_status_phase,
    input  logic cpu_hit,
    input  logic usb_hit,
    output logic cpu_inc,
    output logic usb_inc,
    output logic cnt_clr,
    output logic cpu_wr_ok,
    output logic cpu_rd_ok,
    output logic sod_set,
    output logic eod_set,
    output logic cpu_page,
    output logic cpu_err
);
    own_state_e st_q, st_d;
    logic cpu_done_q, cpu_done_d;
    logic usb_done_q, usb_done_d;
    logic page_d;
    logic err_d;

    logic cpu_open, usb_open;
    logic hand_to_usb, hand_to_cpu, swap;
    logic cpu_fin, usb_fin;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_INIT;
            cpu_done_q <= 1'b0;
            usb_done_q <= 1'b0;
            cpu_page   <= 1'b0;
            cpu_err    <= 1'b0;
        end else begin
            st_q       <= st_d;
            cpu_done_q <= cpu_done_d;
            usb_done_q <= usb_done_d;
            cpu_page   <= page_d;
            cpu_err    <= err_d;
        end
    end

    // next state
    always_comb begin
        st_d       = st_q;
        cpu_done_d = cpu_done_q;
        usb_done_d = usb_done_q;
        page_d     = cpu_page;
        unique case (st_q)
            ST_INIT: begin
                if (cfg_dual) begin
                    st_d       = ST_PINGPONG;
                    usb_done_d = cfg_dir_in;
                    cpu_done_d = !cfg_dir_in;
                end else if (cfg_dir_in) begin
                    st_d = ST_CPU_OWN;
                end else begin
                    st_d = ST_USB_OWN;
                end
            end
            ST_CPU_OWN: begin
                if (hand_to_usb) st_d = ST_USB_OWN;
            end
            ST_USB_OWN: begin
                if (hand_to_cpu) st_d = ST_CPU_OWN;
            end
            ST_PINGPONG: begin
                if (swap) begin
                    cpu_done_d = 1'b0;
                    usb_done_d = 1'b0;
                    page_d     = !cpu_page;
                end else begin
                    cpu_done_d = cpu_fin;
                    usb_done_d = usb_fin;
                end
            end
            default: st_d = ST_INIT;
        endcase
    end

    // outputs
    always_comb begin
        cpu_open    = (st_q == ST_CPU_OWN) || ((st_q == ST_PINGPONG) && !cpu_done_q);
        usb_open    = (st_q == ST_USB_OWN) || ((st_q == ST_PINGPONG) && !usb_done_q);
        cpu_wr_ok   = cpu_open && cfg_dir_in;
        cpu_rd_ok   = cpu_open && !cfg_dir_in;
        cpu_inc     = (cpu_wr && cpu_wr_ok) || (cpu_rd && cpu_rd_ok);
        err_d       = (cpu_wr && !cpu_wr_ok) || (cpu_rd && !cpu_rd_ok);
        usb_inc     = usb_open && usb_xfer && !usb_status_phase;
        cpu_fin     = cpu_done_q || cpu_hit;
        usb_fin     = usb_done_q || usb_hit;
        hand_to_usb = (st_q == ST_CPU_OWN) && cpu_hit;
        hand_to_cpu = (st_q == ST_USB_OWN) && usb_hit;
        swap        = (st_q == ST_PINGPONG) && cpu_fin && usb_fin;
        eod_set     = hand_to_usb || swap;
        sod_set     = hand_to_cpu || swap;
        cnt_clr     = hand_to_usb || hand_to_cpu || swap;
    end
endmodule

// File: rtl/ep_req_flags.sv
module ep_req_flags
    import ep_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sod_set,
    input  logic              eod_set,
    input  logic              sod_clr,
    input  logic              rd,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] set_v, clr_v;

    assign set_v[FLAG_SOD] = sod_set;
    assign set_v[FLAG_EOD] = eod_set;
    assign clr_v[FLAG_SOD] = rd || sod_clr;
    assign clr_v[FLAG_EOD] = rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_v) | set_v;
        end
    end
endmodule

// File: rtl/ep_buf_flags.sv
module ep_buf_flags
    import ep_buf_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dir_in,
    input  logic             cfg_dual,
    input  logic             cfg_ep0,
    input  logic [CNT_W-1:0] cfg_max_len,
    input  logic [CNT_W-1:0] cfg_usb_len,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic             usb_wr,
    input  logic             usb_rd,
    input  logic             usb_setup,
    input  logic             usb_status_phase,
    input  logic             usb_status_in_done,
    input  logic             flags_rd,
    output logic [FLAG_W-1:0] flags_q,
    output logic [CNT_W-1:0] cpu_cnt,
    output logic [CNT_W-1:0] usb_cnt,
    output logic             cpu_wr_ok,
    output logic             cpu_rd_ok,
    output logic             cpu_err,
    output logic             cpu_page
);
    logic             usb_xfer;
    logic             cnt_clr;
    logic             sod_xfer, eod_set, sod_set, sod_clr;
    logic [SIDE_N-1:0] side_inc, side_hit;
    logic [CNT_W-1:0] side_lim [SIDE_N];
    logic [CNT_W-1:0] side_cnt [SIDE_N];

    assign usb_xfer           = cfg_dir_in ? usb_rd : usb_wr;
    assign side_lim[SIDE_CPU] = cfg_dir_in ? cfg_max_len : cfg_usb_len;
    assign side_lim[SIDE_USB] = cfg_usb_len;
    assign sod_set            = sod_xfer || (cfg_ep0 && usb_status_in_done);
    assign sod_clr            = cfg_ep0 && usb_setup;
    assign cpu_cnt            = side_cnt[SIDE_CPU];
    assign usb_cnt            = side_cnt[SIDE_USB];

    ep_own_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_dir_in       (cfg_dir_in),
        .cfg_dual         (cfg_dual),
        .cpu_wr           (cpu_wr),
        .cpu_rd           (cpu_rd),
        .usb_xfer         (usb_xfer),
        .usb_status_phase (usb_status_phase),
        .cpu_hit          (side_hit[SIDE_CPU]),
        .usb_hit          (side_hit[SIDE_USB]),
        .cpu_inc          (side_inc[SIDE_CPU]),
        .usb_inc          (side_inc[SIDE_USB]),
        .cnt_clr          (cnt_clr),
        .cpu_wr_ok        (cpu_wr_ok),
        .cpu_rd_ok        (cpu_rd_ok),
        .sod_set          (sod_xfer),
        .eod_set          (eod_set),
        .cpu_page         (cpu_page),
        .cpu_err          (cpu_err)
    );

    for (genvar s = 0; s < SIDE_N; s++) begin : g_side
        ep_side_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (side_inc[s]),
            .limit (side_lim[s]),
            .cnt   (side_cnt[s]),
            .hit   (side_hit[s])
        );
    end

    ep_req_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .sod_set (sod_set),
        .eod_set (eod_set),
        .sod_clr (sod_clr),
        .rd      (flags_rd),
        .flags   (flags_q)
    );
endmodule

// File: rtl/ep_buf_flags_chk.sv
module ep_buf_flags_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_dual,
    input logic             cfg_ep0,
    input logic             cpu_wr,
    input logic             cpu_rd,
    input logic             usb_status_phase,
    input logic             usb_status_in_done,
    input logic             flags_rd,
    input logic [1:0]       flags_q,
    input logic [CNT_W-1:0] cpu_cnt,
    input logic [CNT_W-1:0] usb_cnt,
    input logic             cpu_wr_ok,
    input logic             cpu_rd_ok,
    input logic             cpu_err,
    input logic             sod_set,
    input logic             eod_set
);
    logic refused;
    assign refused = (cpu_wr && !cpu_wr_ok) || (cpu_rd && !cpu_rd_ok);

    assert_perm_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr_ok && cpu_rd_ok));

    assert_read_clears_eod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !eod_set) |=> !flags_q[1]);

    assert_set_wins_eod_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eod_set |=> flags_q[1]);

    assert_set_wins_sod_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sod_set |=> flags_q[0]);

    assert_refused_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> cpu_err);

    assert_refused_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (refused && !(cpu_wr && cpu_wr_ok) && !(cpu_rd && cpu_rd_ok))
        |=> (cpu_cnt == $past(cpu_cnt) || cpu_cnt == '0));

    assert_swap_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && !(cfg_ep0 && usb_status_in_done)) |-> (sod_set == eod_set));

    assert_status_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        usb_status_phase |=> (usb_cnt == $past(usb_cnt) || usb_cnt == '0));
endmodule

bind ep_buf_flags ep_buf_flags_chk #(.CNT_W(CNT_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .cfg_dual           (cfg_dual),
    .cfg_ep0            (cfg_ep0),
    .cpu_wr             (cpu_wr),
    .cpu_rd             (cpu_rd),
    .usb_status_phase   (usb_status_phase),
    .usb_status_in_done (usb_status_in_done),
    .flags_rd           (flags_rd),
    .flags_q            (flags_q),
    .cpu_cnt            (cpu_cnt),
    .usb_cnt            (usb_cnt),
    .cpu_wr_ok          (cpu_wr_ok),
    .cpu_rd_ok          (cpu_rd_ok),
    .cpu_err            (cpu_err),
    .sod_set            (sod_set),
    .eod_set            (eod_set)
);

// File: tb/ep_buf_flags_bench.sv
module ep_buf_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir = 1'b1, dual = 1'b0, ep0 = 1'b0;
    logic [9:0] max_len = 10'd3, ulen = 10'd2;
    logic       cwr = 0, crd = 0, uwr = 0, urd = 0, setup = 0, stat = 0, sdone = 0, frd = 0;
    logic [1:0] flags_q;
    logic [9:0] cpu_cnt, usb_cnt;
    logic       cpu_wr_ok, cpu_rd_ok, cpu_err, cpu_page;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state: 0 init, 1 cpu owns, 2 usb owns, 3 ping-pong
    int         m_st;
    bit         m_cd, m_ud, m_sod, m_eod, m_err, m_page;
    logic [9:0] m_cc, m_uc;

    always #10 clk = ~clk;

    ep_buf_flags u_ep_buf_flags (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(dir), .cfg_dual(dual), .cfg_ep0(ep0),
        .cfg_max_len(max_len), .cfg_usb_len(ulen), .cpu_wr(cwr), .cpu_rd(crd),
        .usb_wr(uwr), .usb_rd(urd), .usb_setup(setup), .usb_status_phase(stat),
        .usb_status_in_done(sdone), .flags_rd(frd), .flags_q(flags_q),
        .cpu_cnt(cpu_cnt), .usb_cnt(usb_cnt), .cpu_wr_ok(cpu_wr_ok),
        .cpu_rd_ok(cpu_rd_ok), .cpu_err(cpu_err), .cpu_page(cpu_page)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit m_cpu_open();
        return (m_st == 1) || (m_st == 3 && !m_cd);
    endfunction

    function automatic bit m_usb_open();
        return (m_st == 2) || (m_st == 3 && !m_ud);
    endfunction

    task automatic model_step();
        bit wok, rok, cinc, uinc, chit, uhit, sset, eset, cf, uf;
        logic [9:0] climit, nc, nu;
        wok    = m_cpu_open() && dir;
        rok    = m_cpu_open() && !dir;
        cinc   = (cwr && wok) || (crd && rok);
        m_err  = (cwr && !wok) || (crd && !rok);
        climit = dir ? max_len : ulen;
        chit   = cinc && (10'(m_cc + 1) == climit);
        uinc   = m_usb_open() && (dir ? urd : uwr) && !stat;
        uhit   = uinc && (10'(m_uc + 1) == ulen);
        nc = m_cc + 10'(cinc);
        nu = m_uc + 10'(uinc);
        sset = 0; eset = 0;
        case (m_st)
            0: begin
                m_st = dual ? 3 : (dir ? 1 : 2);
                m_ud = dual && dir;
                m_cd = dual && !dir;
            end
            1: if (chit) begin eset = 1; m_st = 2; nc = 0; nu = 0; end
            2: if (uhit) begin sset = 1; m_st = 1; nc = 0; nu = 0; end
            default: begin
                cf = m_cd || chit;
                uf = m_ud || uhit;
                if (cf && uf) begin
                    sset = 1; eset = 1; m_page = !m_page;
                    nc = 0; nu = 0; m_cd = 0; m_ud = 0;
                end else begin
                    m_cd = cf; m_ud = uf;
                end
            end
        endcase
        if (ep0 && sdone) sset = 1;
        m_sod = (m_sod && !frd && !(ep0 && setup)) || sset;
        m_eod = (m_eod && !frd) || eset;
        m_cc = nc;
        m_uc = nu;
    endtask

    task automatic compare_all();
        chk(flags_q[0] == m_sod, "R5 start flag", flags_q[0], m_sod);
        chk(flags_q[1] == m_eod, "R5 end flag", flags_q[1], m_eod);
        chk(cpu_cnt == m_cc, "R1 cpu count", cpu_cnt, m_cc);
        chk(usb_cnt == m_uc, "R3 usb count", usb_cnt, m_uc);
        chk(cpu_wr_ok == (m_cpu_open() && dir), "R7 write permit", cpu_wr_ok, m_cpu_open() && dir);
        chk(cpu_rd_ok == (m_cpu_open() && !dir), "R7 read permit", cpu_rd_ok, m_cpu_open() && !dir);
        chk(cpu_err == m_err, "R7 error pulse", cpu_err, m_err);
        chk(cpu_page == m_page, "R8 page", cpu_page, m_page);
    endtask

    task automatic clear_in();
        cwr = 0; crd = 0; uwr = 0; urd = 0; setup = 0; stat = 0; sdone = 0; frd = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        clear_in();
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst_n = 0;
        repeat (2) @(negedge clk);
        m_st = 0; m_cd = 0; m_ud = 0; m_sod = 0; m_eod = 0; m_err = 0; m_page = 0;
        m_cc = 0; m_uc = 0;
        rst_n = 1;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));

        // single-buffer transmit
        dir = 1; dual = 0; ep0 = 0; max_len = 3; ulen = 2;
        do_reset();
        chk(flags_q == 0 && cpu_cnt == 0 && usb_cnt == 0, "R11 reset state", flags_q, 0);
        chk(!cpu_wr_ok && !cpu_rd_ok, "R11 no access in first cycle", cpu_wr_ok, 0);
        tick();
        chk(cpu_wr_ok == 1, "R11 cpu owns transmit buffer", cpu_wr_ok, 1);
        repeat (2) begin cwr = 1; tick(); end
        chk(cpu_cnt == 2 && flags_q[1] == 0, "R1 partial fill", cpu_cnt, 2);
        cwr = 1; tick();
        chk(flags_q[1] == 1 && cpu_wr_ok == 0 && cpu_cnt == 0, "R1 full at max length", flags_q[1], 1);
        cwr = 1; tick();
        chk(cpu_err == 1 && cpu_cnt == 0, "R7 refused write", cpu_err, 1);
        tick();
        chk(cpu_err == 0, "R7 pulse is one cycle", cpu_err, 0);
        repeat (2) begin urd = 1; stat = 1; tick(); end
        chk(usb_cnt == 0 && flags_q[0] == 0, "R9 status phase ignored", usb_cnt, 0);
        repeat (2) begin urd = 1; tick(); end
        chk(flags_q[0] == 1 && cpu_wr_ok == 1, "R3 drained by usb", flags_q[0], 1);
        frd = 1; tick();
        chk(flags_q == 0, "R5 read clears", flags_q, 0);

        // single-buffer receive
        dir = 0; ulen = 2;
        do_reset();
        tick();
        chk(cpu_rd_ok == 0, "R4 reads blocked while empty", cpu_rd_ok, 0);
        repeat (2) begin uwr = 1; tick(); end
        chk(flags_q[0] == 1 && cpu_rd_ok == 1, "R4 filled by usb", flags_q[0], 1);
        crd = 1; tick();
        crd = 1; frd = 1; tick();
        chk(flags_q == 2'b10, "R6 set wins over read", flags_q, 2);
        chk(cpu_rd_ok == 0, "R2 reads refused when empty", cpu_rd_ok, 0);

        // ping-pong transmit
        dir = 1; dual = 1; max_len = 2; ulen = 2;
        do_reset();
        tick();
        repeat (2) begin cwr = 1; tick(); end
        chk(flags_q == 2'b11 && cpu_page == 1, "R8 first swap", flags_q, 3);
        frd = 1; tick();
        repeat (2) begin cwr = 1; tick(); end
        chk(flags_q == 0 && cpu_wr_ok == 0, "R8 cpu waits for usb", flags_q, 0);
        urd = 1; tick();
        chk(flags_q == 0 && cpu_page == 1, "R8 no swap yet", cpu_page, 1);
        urd = 1; tick();
        chk(flags_q == 2'b11 && cpu_page == 0 && cpu_cnt == 0, "R8 second swap", flags_q, 3);

        // endpoint 0 status rules
        dir = 1; dual = 0; ep0 = 1; max_len = 4; ulen = 4;
        do_reset();
        tick();
        sdone = 1; tick();
        chk(flags_q[0] == 1, "R10 status-in sets start flag", flags_q[0], 1);
        setup = 1; tick();
        chk(flags_q[0] == 0, "R10 setup clears start flag", flags_q[0], 0);
        setup = 1; sdone = 1; tick();
        chk(flags_q[0] == 1, "R10 set wins over setup", flags_q[0], 1);

        // random traffic over all modes
        for (int cfg = 0; cfg < 4; cfg++) begin
            dir = cfg[0]; dual = cfg[1]; ep0 = $urandom % 2;
            max_len = 10'(1 + $urandom % 5);
            ulen    = 10'(1 + $urandom % 5);
            do_reset();
            for (int n = 0; n < 1500; n++) begin
                cwr   = ($urandom % 3) == 0;
                crd   = ($urandom % 3) == 0;
                uwr   = ($urandom % 2) == 0;
                urd   = ($urandom % 2) == 0;
                stat  = ($urandom % 10) == 0;
                setup = ($urandom % 20) == 0;
                sdone = ($urandom % 20) == 0;
                frd   = ($urandom % 4) == 0;
                tick();
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule